// File: doc/BRIEF.md
# Hamming SEC-DED Memory Word Codec

This block protects a 16-bit memory word with a distance-four Hamming code. The write path spreads the data over a 21-position word. Even-parity check bits sit at the power-of-two positions 1, 2, 4, 8 and 16, and the data fills every other position. One further bit, position 22, holds the even parity of all 21 positions. The result is a 22-bit stored word.

The read path takes a fetched 22-bit word and recomputes each check bit from the data positions. Together with the stored check bits this yields a 5-bit position syndrome that names the flipped position directly. The path also tests the parity of the whole word. From these two results it returns the data, repaired where possible, along with a three-way status.

Both paths hold a result register, so each has one cycle of latency. The two paths are independent and can be used in the same cycle. Every cycle loads a new result, and there is no handshake.

Top module: `hcodec_top`

## Requirements
- R1: Data bit 15 (the leftmost bit) is placed at position 3, and the remaining data bits fill positions 5, 6, 7, 9 to 15 and 17 to 21 in descending bit order. Position p of the stored word appears on port bit p-1.
- R2: The check bit at position 2^i is chosen so that the parity is even over all positions 1 to 21 whose index has bit i set.
- R3: Position 22 (port bit 21) makes the total count of ones in the 22-bit word even.
- R4: Data 16'hF0AE encodes to 22'h0ED074. Read from position 1 to position 21, those bits are 001011100000101101110, and position 22 is 0.
- R5: A fetched word with a zero syndrome and even overall parity gives status 0 (no error), syndrome 0, and the data taken from the data positions unchanged.
- R6: A fetched word with exactly one flipped bit at any position 1 to 21 gives status 1 (corrected), a syndrome equal to that position, and the original data.
- R7: Flipping position 5 of the R4 word makes check positions 1 and 4 fail and positions 2, 8 and 16 pass. The syndrome is therefore 5, the status is 1, and the data is 16'hF0AE.
- R8: A word in which only position 22 is flipped gives status 1, syndrome 0, and unchanged data.
- R9: A nonzero syndrome with even overall parity, such as any two flipped bits, gives status 2 (uncorrectable). The data output is the uncorrected content of the data positions.
- R10: A syndrome above 21 with odd overall parity gives status 2 and uncorrected data. Any other odd-parity word with a nonzero syndrome is treated as a single error at the position the syndrome names.
- R11: Encode and decode results each appear on the outputs one clock edge after their inputs are sampled, and they hold until the next edge.
- R12: A synchronous active-high reset clears the stored word, the data output, the syndrome and the status to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_data_i | input | 16 | Data word to encode |
| enc_word_o | output | 22 | Registered stored word; bit p-1 is position p |
| dec_word_i | input | 22 | Fetched word to check and repair |
| dec_data_o | output | 16 | Registered repaired or raw data |
| dec_status_o | output | 2 | 0 no error, 1 corrected, 2 uncorrectable |
| dec_syn_o | output | 5 | Registered position syndrome |

## Verification
Encoding and decoding can both be active on the same clock edge, and they share the package-derived position tables. Every stimulus step therefore loads a new data word into the encoder while the decoder receives a corrupted word built from a different codeword. Both results are compared on the same sample against arithmetic models in the bench. The bench's decode model finds the syndrome as the XOR of the indices of the set bits, so its expected values are derived independently of the mask-based logic. A mismatch on either path therefore shows up even when the other path is busy in that cycle.

// File: rtl/hcodec_pkg.sv
package hcodec_pkg;

    localparam int DATA_W = 16;

    function automatic int calc_chk_w(input int dw);
        int k;
        k = 0;
        while ((1 << k) < dw + k + 1) k++;
        return k;
    endfunction

    localparam int CHK_W  = calc_chk_w(DATA_W);
    localparam int CODE_W = DATA_W + CHK_W;
    localparam int FULL_W = CODE_W + 1;

    typedef enum logic [1:0] {
        RD_CLEAN = 2'd0,
        RD_FIXED = 2'd1,
        RD_FATAL = 2'd2
    } rd_status_e;

    typedef enum logic [2:0] {
        CL_QUIET        = 3'd0,
        CL_TAIL_ONLY    = 3'd1,
        CL_SINGLE       = 3'd2,
        CL_OUT_OF_RANGE = 3'd3,
        CL_EVEN_MULTI   = 3'd4
    } rd_class_e;

    // 1-indexed position holds a check bit when it is a power of two
    function automatic bit is_chk_pos(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // position of data slot j, slot 0 carrying the most significant data bit
    function automatic int slot_pos(input int j);
        int seen;
        int res;
        seen = 0;
        res  = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (!is_chk_pos(p)) begin
                if (seen == j) res = p;
                seen++;
            end
        end
        return res;
    endfunction

    // positions whose index has bit i set
    function automatic logic [CODE_W-1:0] cover_mask(input int i);
        logic [CODE_W-1:0] m;
        m = '0;
        for (int p = 1; p <= CODE_W; p++) m[p-1] = ((p >> i) & 1) == 1;
        return m;
    endfunction

endpackage

// File: rtl/hc_encoder.sv
module hc_encoder
    import hcodec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] data_i,
    output logic [FULL_W-1:0] word_o
);

    logic [CODE_W-1:0] spread;
    logic [CHK_W-1:0]  chk;
    logic [CODE_W-1:0] body;
    logic              tail;

    for (genvar j = 0; j < DATA_W; j++) begin : g_place
        localparam int POS = slot_pos(j);
        assign spread[POS-1] = data_i[DATA_W-1-j];
    end

    for (genvar i = 0; i < CHK_W; i++) begin : g_chk
        localparam logic [CODE_W-1:0] MASK = cover_mask(i);
        assign spread[(1 << i) - 1] = 1'b0;
        assign chk[i] = ^(spread & MASK);
    end

    always_comb begin
        body = spread;
        for (int i = 0; i < CHK_W; i++) body[(1 << i) - 1] = chk[i];
    end

    assign tail = ^body;

    always_ff @(posedge clk) begin
        if (rst) word_o <= '0;
        else     word_o <= {tail, body};
    end

endmodule

// File: rtl/hc_syndrome.sv
module hc_syndrome
    import hcodec_pkg::*;
(
    input  logic [FULL_W-1:0] word_i,
    output logic [CHK_W-1:0]  syn_o,
    output logic              tail_fail_o
);

    for (genvar i = 0; i < CHK_W; i++) begin : g_syn
        localparam logic [CODE_W-1:0] MASK = cover_mask(i);
        assign syn_o[i] = ^(word_i[CODE_W-1:0] & MASK);
    end

    assign tail_fail_o = ^word_i;

endmodule

// File: rtl/hc_corrector.sv
module hc_corrector
    import hcodec_pkg::*;
(
    input  logic [CODE_W-1:0] body_i,
    input  logic [CHK_W-1:0]  syn_i,
    input  logic              tail_fail_i,
    output logic [DATA_W-1:0] data_o,
    output rd_status_e        status_o
);

    rd_class_e         cls;
    logic [CODE_W-1:0] flip;
    logic [CODE_W-1:0] fixed;

    always_comb begin
        if (syn_i == '0)                 cls = tail_fail_i ? CL_TAIL_ONLY : CL_QUIET;
        else if (!tail_fail_i)           cls = CL_EVEN_MULTI;
        else if (int'(syn_i) > CODE_W)   cls = CL_OUT_OF_RANGE;
        else                             cls = CL_SINGLE;
    end

    always_comb begin
        flip     = '0;
        status_o = RD_CLEAN;
        unique case (cls)
            CL_QUIET:        status_o = RD_CLEAN;
            CL_TAIL_ONLY:    status_o = RD_FIXED;
            CL_SINGLE: begin
                status_o = RD_FIXED;
                flip     = {{(CODE_W-1){1'b0}}, 1'b1} << (syn_i - 1'b1);
            end
            CL_OUT_OF_RANGE: status_o = RD_FATAL;
            CL_EVEN_MULTI:   status_o = RD_FATAL;
            default:         status_o = RD_FATAL;
        endcase
    end

    assign fixed = body_i ^ flip;

    for (genvar j = 0; j < DATA_W; j++) begin : g_pull
        localparam int POS = slot_pos(j);
        assign data_o[DATA_W-1-j] = fixed[POS-1];
    end

endmodule

// File: rtl/hcodec_top.sv
module hcodec_top
    import hcodec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [FULL_W-1:0] enc_word_o,
    input  logic [FULL_W-1:0] dec_word_i,
    output logic [DATA_W-1:0] dec_data_o,
    output logic [1:0]        dec_status_o,
    output logic [CHK_W-1:0]  dec_syn_o
);

    logic [CHK_W-1:0]  syn_w;
    logic              tail_fail_w;
    logic [DATA_W-1:0] data_w;
    rd_status_e        status_w;

    logic [DATA_W-1:0] data_q;
    rd_status_e        status_q;
    logic [CHK_W-1:0]  syn_q;

    hc_encoder u_enc (
        .clk    (clk),
        .rst    (rst),
        .data_i (enc_data_i),
        .word_o (enc_word_o)
    );

    hc_syndrome u_syn (
        .word_i      (dec_word_i),
        .syn_o       (syn_w),
        .tail_fail_o (tail_fail_w)
    );

    hc_corrector u_fix (
        .body_i      (dec_word_i[CODE_W-1:0]),
        .syn_i       (syn_w),
        .tail_fail_i (tail_fail_w),
        .data_o      (data_w),
        .status_o    (status_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q   <= '0;
            status_q <= RD_CLEAN;
            syn_q    <= '0;
        end else begin
            data_q   <= data_w;
            status_q <= status_w;
            syn_q    <= syn_w;
        end
    end

    assign dec_data_o   = data_q;
    assign dec_status_o = status_q;
    assign dec_syn_o    = syn_q;

endmodule

// File: rtl/hcodec_chk.sv
module hcodec_chk
    import hcodec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] enc_data_i,
    input logic [FULL_W-1:0] enc_word_o,
    input logic [FULL_W-1:0] dec_word_i,
    input logic [DATA_W-1:0] dec_data_o,
    input logic [1:0]        dec_status_o,
    input logic [CHK_W-1:0]  dec_syn_o
);

    function automatic logic [CHK_W-1:0] pos_xor(input logic [FULL_W-1:0] w);
        logic [CHK_W-1:0] x;
        x = '0;
        for (int p = 1; p <= CODE_W; p++) if (w[p-1]) x = x ^ CHK_W'(p);
        return x;
    endfunction

    function automatic logic [DATA_W-1:0] pull(input logic [FULL_W-1:0] w);
        logic [DATA_W-1:0] d;
        int j;
        d = '0;
        j = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (!is_chk_pos(p)) begin
                d[DATA_W-1-j] = w[p-1];
                j++;
            end
        end
        return d;
    endfunction

    // R2
    enc_checks_even_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> pos_xor(enc_word_o) == '0);

    // R3
    enc_tail_even_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (^enc_word_o) == 1'b0);

    // R1
    enc_place_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> pull(enc_word_o) == $past(enc_data_i));

    // R5
    dec_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && pos_xor($past(dec_word_i)) == '0 && (^$past(dec_word_i)) == 1'b0)
        |-> (dec_status_o == 2'd0 && dec_data_o == pull($past(dec_word_i))));

    // R9
    dec_fatal_raw_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && dec_status_o == 2'd2) |-> dec_data_o == pull($past(dec_word_i)));

    // R6
    dec_syn_track_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> dec_syn_o == pos_xor($past(dec_word_i)));

    // R10
    dec_status_legal_chk: assert property (@(posedge clk) disable iff (rst)
        dec_status_o != 2'd3);

    // R12
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dec_status_o == 2'd0 && dec_data_o == '0 && dec_syn_o == '0 && enc_word_o == '0));

endmodule

bind hcodec_top hcodec_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .enc_data_i   (enc_data_i),
    .enc_word_o   (enc_word_o),
    .dec_word_i   (dec_word_i),
    .dec_data_o   (dec_data_o),
    .dec_status_o (dec_status_o),
    .dec_syn_o    (dec_syn_o)
);

// File: tb/hcodec_top_tb_top.sv
module hcodec_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] enc_d = 16'hA5A5;
    logic [21:0] dec_w = 22'h3FFFFF;
    logic [21:0] enc_word_o;
    logic [15:0] dec_data_o;
    logic [1:0]  dec_status_o;
    logic [4:0]  dec_syn_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    hcodec_top dut_i (
        .clk          (clk),
        .rst          (rst),
        .enc_data_i   (enc_d),
        .enc_word_o   (enc_word_o),
        .dec_word_i   (dec_w),
        .dec_data_o   (dec_data_o),
        .dec_status_o (dec_status_o),
        .dec_syn_o    (dec_syn_o)
    );

    function automatic bit pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    // arithmetic model: check bits make the XOR of set positions zero
    function automatic logic [21:0] m_encode(input logic [15:0] d);
        logic [21:0] w;
        int j;
        int x;
        w = '0;
        j = 15;
        x = 0;
        for (int p = 1; p <= 21; p++) begin
            if (!pow2(p)) begin
                w[p-1] = d[j];
                if (d[j]) x = x ^ p;
                j--;
            end
        end
        for (int i = 0; i < 5; i++) w[(1 << i) - 1] = x[i];
        w[21] = ^w[20:0];
        return w;
    endfunction

    function automatic logic [15:0] m_pull(input logic [21:0] w);
        logic [15:0] d;
        int j;
        d = '0;
        j = 15;
        for (int p = 1; p <= 21; p++) begin
            if (!pow2(p)) begin
                d[j] = w[p-1];
                j--;
            end
        end
        return d;
    endfunction

    task automatic m_decode(input logic [21:0] w, output logic [15:0] d,
                            output logic [1:0] st, output logic [4:0] syn);
        int x;
        logic par;
        logic [21:0] fixed;
        x = 0;
        for (int p = 1; p <= 21; p++) if (w[p-1]) x = x ^ p;
        par   = ^w;
        fixed = w;
        if (x == 0)          st = par ? 2'd1 : 2'd0;
        else if (!par)       st = 2'd2;
        else if (x > 21)     st = 2'd2;
        else begin
            st = 2'd1;
            fixed[x-1] = ~fixed[x-1];
        end
        syn = x[4:0];
        d   = m_pull(fixed);
    endtask

    task automatic step(input logic [15:0] ed, input logic [21:0] dw, input string tag);
        logic [21:0] exp_w;
        logic [15:0] exp_d;
        logic [1:0]  exp_s;
        logic [4:0]  exp_y;
        @(negedge clk);
        enc_d = ed;
        dec_w = dw;
        @(negedge clk);
        exp_w = m_encode(ed);
        m_decode(dw, exp_d, exp_s, exp_y);
        total++;
        if (enc_word_o !== exp_w) begin
            bad++;
            $display("FAIL R1 R2 R3 encode of %h: got %h exp %h", ed, enc_word_o, exp_w);
        end
        total++;
        if (dec_data_o !== exp_d || dec_status_o !== exp_s || dec_syn_o !== exp_y) begin
            bad++;
            $display("FAIL %s decode of %h: got d=%h s=%0d y=%0d exp d=%h s=%0d y=%0d",
                     tag, dw, dec_data_o, dec_status_o, dec_syn_o, exp_d, exp_s, exp_y);
        end
    endtask

    task automatic expect_eq(input logic [31:0] got, input logic [31:0] exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got running exp finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        logic [15:0] wordlist [48];
        logic [21:0] cw;

        // R12: reset state with busy inputs
        repeat (3) @(negedge clk);
        expect_eq({10'd0, enc_word_o}, 32'd0, "R12 enc word in reset");
        expect_eq({14'd0, dec_status_o, dec_data_o}, 32'd0, "R12 status/data in reset");
        expect_eq({27'd0, dec_syn_o}, 32'd0, "R12 syndrome in reset");
        rst = 1'b0;

        // R4 and R7: known vector and its position-5 flip
        step(16'hF0AE, 22'h0ED074 ^ 22'h000010, "R7");
        expect_eq({10'd0, enc_word_o}, 32'h000ED074, "R4 known codeword");
        expect_eq({27'd0, dec_syn_o}, 32'd5, "R7 syndrome names position 5");
        expect_eq({30'd0, dec_status_o}, 32'd1, "R7 status corrected");
        expect_eq({16'd0, dec_data_o}, 32'h0000F0AE, "R7 restored data");

        // R11: outputs hold until the next edge, then follow
        @(negedge clk);
        enc_d = 16'h1234;
        dec_w = m_encode(16'h1234);
        #1;
        expect_eq({10'd0, enc_word_o}, 32'h000ED074, "R11 encode holds before edge");
        expect_eq({16'd0, dec_data_o}, 32'h0000F0AE, "R11 decode holds before edge");
        @(negedge clk);
        expect_eq({10'd0, enc_word_o}, {10'd0, m_encode(16'h1234)}, "R11 encode after one edge");
        expect_eq({16'd0, dec_data_o}, 32'h00001234, "R11 decode after one edge");

        // word list: walking ones, walking zeros, extremes, pseudo-random
        lf = 16'hACE1;
        for (int k = 0; k < 48; k++) begin
            if (k < 16)       wordlist[k] = 16'd1 << k;
            else if (k < 32)  wordlist[k] = ~(16'd1 << (k - 16));
            else if (k == 32) wordlist[k] = 16'h0000;
            else if (k == 33) wordlist[k] = 16'hFFFF;
            else begin
                lf = lf[0] ? ((lf >> 1) ^ 16'hB400) : (lf >> 1);
                wordlist[k] = lf;
            end
        end

        // encode and decode run in the same cycles on different words
        for (int k = 0; k < 48; k++) begin
            cw = m_encode(wordlist[k]);
            step(wordlist[(k + 7) % 48], cw, "R5");
            for (int p = 0; p < 22; p++)
                step(wordlist[(k + p) % 48], cw ^ (22'd1 << p), (p == 21) ? "R8" : "R6");
            for (int a = 0; a < 22; a++) begin
                int b;
                b = (a + 1 + (k % 21)) % 22;
                step(wordlist[(k + a + 3) % 48], cw ^ (22'd1 << a) ^ (22'd1 << b), "R9");
            end
        end

        // R9: every pair on one word
        cw = m_encode(16'h5A3C);
        for (int a = 0; a < 22; a++)
            for (int b = a + 1; b < 22; b++)
                step(16'(a * 31 + b), cw ^ (22'd1 << a) ^ (22'd1 << b), "R9");

        // R10: every triple on one word
        cw = m_encode(16'hC3E1);
        for (int a = 0; a < 22; a++)
            for (int b = a + 1; b < 22; b++)
                for (int c = b + 1; c < 22; c++)
                    step(16'(a + b * 22 + c * 484), cw ^ (22'd1 << a) ^ (22'd1 << b) ^ (22'd1 << c), "R10");

        // R10: positions 1, 8, 16 give syndrome 25
        step(16'h0F0F, cw ^ 22'h000001 ^ 22'h000080 ^ 22'h008000, "R10");
        expect_eq({30'd0, dec_status_o}, 32'd2, "R10 out-of-range status");
        expect_eq({16'd0, dec_data_o}, {16'd0, m_pull(cw ^ 22'h000001 ^ 22'h000080 ^ 22'h008000)}, "R10 raw data");

        // R12: reset in the middle of an error report
        step(16'h7777, cw ^ 22'h000003, "R9");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        expect_eq({30'd0, dec_status_o}, 32'd0, "R12 mid-run reset status");
        expect_eq({10'd0, enc_word_o}, 32'd0, "R12 mid-run reset word");
        rst = 1'b0;

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule